// File: doc/BRIEF.md
# Transmit PHY reset sequencer

This block brings a serial transmit path and its PLL out of reset in a fixed order. It takes one reset input and one PLL lock status input. It drives a PLL power-down output, plus an analog reset, a digital reset and a ready flag for each of `NUM_CH` channels. Every hold time is a parameter in nanoseconds. The parameter is converted to cycles of the free-running controller clock by rounding up.

After reset is released, the sequence runs in this order:
1. Power-down is released first.
2. The sequencer waits until the lock input has passed its hysteresis filter.
3. The analog reset is released.
4. The digital reset is released, and ready rises in the same cycle.

If lock is lost while running, the behaviour depends on the recovery mode. In automatic recovery, only the digital reset is asserted again, until lock is accepted once more. In manual recovery, the running state is left alone. The mode is fixed by a parameter, or it can be chosen at run time through a select input. Asserting the reset input at any time sends the sequencer back to power-down.

Top module: `tx_reset_seq`

## Requirements
- R1: A duration of D ns at CLK_MHZ MHz becomes ceil(D*CLK_MHZ/1000) cycles, with a minimum of 1. At 50 MHz, the default 1000 ns power-down lasts 50 cycles.
- R2: While `rstIn` is high, the outputs are in their reset state: `pllPowerDown`=1, every `txAnalogReset` bit =1, every `txDigitalReset` bit =1, and every `txReady` bit =0.
- R3: `pllPowerDown` stays high for the power-down cycle count after the internal reset is released. With SYNC_RST=1, release passes through a two-flop synchronizer, which adds 2 cycles. With SYNC_RST=0, `rstIn` is used directly.
- R4: Once power-down is released and the filtered lock is seen, the sequencer enters the analog phase on the next cycle. The analog reset is released after the analog cycle count has elapsed in that phase.
- R5: The digital reset is released the digital cycle count after the analog release. `txReady` rises in that same cycle. All channel bits always carry the same value.
- R6: `pllLocked` is accepted only after it has stayed high for the hysteresis cycle count. A shorter high pulse is ignored. A hysteresis of 0 ns passes the input straight through.
- R7: In automatic recovery, loss of accepted lock while ready re-asserts the digital reset and clears ready. The analog reset stays low. After lock is accepted again, the digital reset is released once the digital cycle count has elapsed.
- R8: Recovery selection works as follows:
  - MODE=0 is automatic.
  - MODE=1 is manual.
  - MODE=2 follows `manualSel`, where 1 selects manual and 0 selects automatic.
  - In manual recovery, loss of lock leaves the digital reset low and ready high.
- R9: Raising `rstIn` at any time immediately returns every output to the R2 state. It also restarts the whole sequence from power-down, including a sequence that is still in progress.
- R10: With FAST_SIM=1, each R1 cycle count c is replaced by ceil(c/16), with a minimum of 1.
- R11: The analog reset is never low while power-down is high. The digital reset is never low while the analog reset is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running controller clock |
| rstIn | input | 1 | Active-high reset request; asserts asynchronously |
| pllLocked | input | 1 | PLL lock status, synchronous to `clk` |
| manualSel | input | 1 | Run-time recovery select when MODE=2 (1 = manual) |
| pllPowerDown | output | 1 | PLL power-down |
| txAnalogReset | output | NUM_CH | Per-channel analog reset |
| txDigitalReset | output | NUM_CH | Per-channel digital reset |
| txReady | output | NUM_CH | Per-channel ready |

## Verification
The bench times every release edge exactly, to the cycle, including the two cycles of synchronizer latency. A design with an off-by-one counter, or one that counts the analog phase before lock is accepted, shows up at once as a mistimed edge.

The bench also exercises the following corner cases:
- **Short lock pulse.** A pulse shorter than the hysteresis window is applied. A design without proper filtering would release the digital reset early.
- **Automatic recovery.** A lock drop is applied in automatic mode. A design that restarts the analog phase would pulse the analog reset, and the bench flags that change.
- **Manual recovery.** Manual selection is switched on at run time and lock is dropped. Ready must stay high.
- **Reset in mid power-down.** `rstIn` is asserted while power-down is still running. A counter that fails to reload would release too early.

A second instance is also checked, with fast simulation, no synchronizer and zero hysteresis. It shows that the shortened counts and the unfiltered lock path are used.

// File: rtl/tx_rst_pkg.sv
package tx_rst_pkg;

  typedef enum logic [2:0] {
    ST_PDN, ST_WAIT, ST_ANA, ST_DIG, ST_RELOCK, ST_RUN
  } seqState_t;

  typedef enum logic [1:0] {LD_PDN, LD_ANA, LD_DIG} loadSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;
    loadSel_t sel;
    logic     dec;
  } cntCmd_t;

  // round a nanosecond duration up to whole cycles, never below one
  function automatic int unsigned nsToCyc(int unsigned ns, int unsigned mhz, bit fast);
    longint unsigned prod;
    longint unsigned c;
    prod = longint'(ns) * longint'(mhz);
    c = (prod + 999) / 1000;
    if (c < 1) c = 1;
    if (fast) c = (c + 15) / 16;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

  // hysteresis may be zero, which means no filter
  function automatic int unsigned hystCyc(int unsigned ns, int unsigned mhz, bit fast);
    if (ns == 0) return 0;
    return nsToCyc(ns, mhz, fast);
  endfunction

endpackage

// File: rtl/tx_rst_sync.sv
module tx_rst_sync #(
  parameter int STAGES = 2,
  parameter bit ENABLE = 1'b1
) (
  input  logic clk,
  input  logic rstIn,
  output logic rstOut
);
  generate
    if (ENABLE) begin : g_sync
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or posedge rstIn) begin
        if (rstIn) chain <= '1;
        else       chain <= {chain[STAGES-2:0], 1'b0};
      end
      assign rstOut = chain[STAGES-1];
    end else begin : g_direct
      assign rstOut = rstIn;
    end
  endgenerate
endmodule

// File: rtl/tx_rst_datapath.sv
module tx_rst_datapath
  import tx_rst_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int PDN_CYC  = 50,
  parameter int ANA_CYC  = 10,
  parameter int DIG_CYC  = 5,
  parameter int HYST_CYC = 10,
  parameter int HYST_W   = 4
) (
  input  logic    clk,
  input  logic    rstInt,
  input  logic    pllLocked,
  input  cntCmd_t cmd,
  output logic    cntDone,
  output logic    lockOk
);
  logic [CNT_W-1:0] durCnt;

  // shared duration counter, reloaded per phase by the control
  always_ff @(posedge clk or posedge rstInt) begin
    if (rstInt) begin
      durCnt <= CNT_W'(PDN_CYC);
    end else if (cmd.load) begin
      case (cmd.sel)
        LD_ANA:  durCnt <= CNT_W'(ANA_CYC);
        LD_DIG:  durCnt <= CNT_W'(DIG_CYC);
        default: durCnt <= CNT_W'(PDN_CYC);
      endcase
    end else if (cmd.dec && durCnt > CNT_W'(1)) begin
      durCnt <= durCnt - CNT_W'(1);
    end
  end

  assign cntDone = (durCnt <= CNT_W'(1));

  // lock hysteresis filter
  generate
    if (HYST_CYC == 0) begin : g_nofilt
      assign lockOk = pllLocked;
    end else begin : g_filt
      logic [HYST_W-1:0] hystCnt;
      always_ff @(posedge clk or posedge rstInt) begin
        if (rstInt)                            hystCnt <= '0;
        else if (!pllLocked)                   hystCnt <= '0;
        else if (hystCnt != HYST_W'(HYST_CYC)) hystCnt <= hystCnt + HYST_W'(1);
      end
      assign lockOk = (hystCnt == HYST_W'(HYST_CYC));
    end
  endgenerate
endmodule

// File: rtl/tx_rst_ctrl.sv
module tx_rst_ctrl
  import tx_rst_pkg::*;
(
  input  logic      clk,
  input  logic      rstInt,
  input  logic      cntDone,
  input  logic      lockOk,
  input  logic      manualEff,
  output cntCmd_t   cmd,
  output seqState_t state
);
  seqState_t nextState;

  always_ff @(posedge clk or posedge rstInt) begin
    if (rstInt) state <= ST_PDN;
    else        state <= nextState;
  end

  always_comb begin
    nextState = state;
    cmd = '{load: 1'b0, sel: LD_PDN, dec: 1'b0};
    case (state)
      ST_PDN: begin
        if (cntDone) nextState = ST_WAIT;
        else         cmd.dec = 1'b1;
      end
      ST_WAIT: begin
        if (lockOk) begin
          nextState = ST_ANA;
          cmd.load = 1'b1;
          cmd.sel = LD_ANA;
        end
      end
      ST_ANA: begin
        if (!lockOk) begin
          nextState = ST_WAIT;
        end else if (cntDone) begin
          nextState = ST_DIG;
          cmd.load = 1'b1;
          cmd.sel = LD_DIG;
        end else begin
          cmd.dec = 1'b1;
        end
      end
      ST_RELOCK: begin
        if (lockOk) begin
          nextState = ST_DIG;
          cmd.load = 1'b1;
          cmd.sel = LD_DIG;
        end
      end
      ST_DIG: begin
        if (!lockOk)      nextState = ST_RELOCK;
        else if (cntDone) nextState = ST_RUN;
        else              cmd.dec = 1'b1;
      end
      ST_RUN: begin
        if (!lockOk && !manualEff) nextState = ST_RELOCK;
      end
      default: nextState = ST_PDN;
    endcase
  end
endmodule

// File: rtl/tx_reset_seq.sv
module tx_reset_seq
  import tx_rst_pkg::*;
#(
  parameter int NUM_CH       = 2,
  parameter int CLK_MHZ      = 50,
  parameter int PDN_NS       = 1000,
  parameter int ANA_NS       = 200,
  parameter int DIG_NS       = 100,
  parameter int LOCK_HYST_NS = 200,
  parameter bit SYNC_RST     = 1'b1,
  parameter bit FAST_SIM     = 1'b0,
  parameter int MODE         = 2
) (
  input  logic              clk,
  input  logic              rstIn,
  input  logic              pllLocked,
  input  logic              manualSel,
  output logic              pllPowerDown,
  output logic [NUM_CH-1:0] txAnalogReset,
  output logic [NUM_CH-1:0] txDigitalReset,
  output logic [NUM_CH-1:0] txReady
);
  localparam int PDN_CYC  = int'(nsToCyc(PDN_NS, CLK_MHZ, FAST_SIM));
  localparam int ANA_CYC  = int'(nsToCyc(ANA_NS, CLK_MHZ, FAST_SIM));
  localparam int DIG_CYC  = int'(nsToCyc(DIG_NS, CLK_MHZ, FAST_SIM));
  localparam int HYST_CYC = int'(hystCyc(LOCK_HYST_NS, CLK_MHZ, FAST_SIM));
  localparam int MAX_AD   = (ANA_CYC > DIG_CYC) ? ANA_CYC : DIG_CYC;
  localparam int MAX_CYC  = (PDN_CYC > MAX_AD) ? PDN_CYC : MAX_AD;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);
  localparam int HYST_W   = (HYST_CYC < 2) ? 1 : $clog2(HYST_CYC + 1);

  logic      rstInt;
  logic      cntDone;
  logic      lockOk;
  logic      manualEff;
  cntCmd_t   cmd;
  seqState_t state;
  logic      anaOn;
  logic      digOn;
  logic      runOn;

  tx_rst_sync #(.STAGES(2), .ENABLE(SYNC_RST)) sync_i (
    .clk(clk), .rstIn(rstIn), .rstOut(rstInt)
  );

  tx_rst_datapath #(
    .CNT_W(CNT_W), .PDN_CYC(PDN_CYC), .ANA_CYC(ANA_CYC),
    .DIG_CYC(DIG_CYC), .HYST_CYC(HYST_CYC), .HYST_W(HYST_W)
  ) dp_i (
    .clk(clk), .rstInt(rstInt), .pllLocked(pllLocked),
    .cmd(cmd), .cntDone(cntDone), .lockOk(lockOk)
  );

  tx_rst_ctrl ctrl_i (
    .clk(clk), .rstInt(rstInt), .cntDone(cntDone), .lockOk(lockOk),
    .manualEff(manualEff), .cmd(cmd), .state(state)
  );

  assign manualEff = (MODE == 1) || ((MODE == 2) && manualSel);

  assign pllPowerDown = (state == ST_PDN);
  assign anaOn = (state == ST_PDN) || (state == ST_WAIT) || (state == ST_ANA);
  assign digOn = (state != ST_RUN);
  assign runOn = (state == ST_RUN);

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      assign txAnalogReset[ch]  = anaOn;
      assign txDigitalReset[ch] = digOn;
      assign txReady[ch]        = runOn;
    end
  endgenerate
endmodule

// File: rtl/tx_reset_seq_chk.sv
module tx_reset_seq_chk #(
  parameter int NUM_CH = 2,
  parameter int MODE   = 2
) (
  input logic              clk,
  input logic              rstIn,
  input logic              pllLocked,
  input logic              manualSel,
  input logic              pllPowerDown,
  input logic [NUM_CH-1:0] txAnalogReset,
  input logic [NUM_CH-1:0] txDigitalReset,
  input logic [NUM_CH-1:0] txReady
);
  logic manualNow;
  assign manualNow = (MODE == 1) || ((MODE == 2) && manualSel);

  // R9: reset request forces the reset state
  a_r9_reset_state: assert property (@(posedge clk)
    rstIn |-> (pllPowerDown && (&txAnalogReset) && (&txDigitalReset) && (txReady == '0)));

  // R11: release ordering
  a_r11_pdn_before_ana: assert property (@(posedge clk) disable iff (rstIn)
    pllPowerDown |-> (&txAnalogReset));
  a_r11_ana_before_dig: assert property (@(posedge clk) disable iff (rstIn)
    (|txAnalogReset) |-> (&txDigitalReset));

  // R6: analog release only follows an accepted lock
  a_r6_ana_needs_lock: assert property (@(posedge clk) disable iff (rstIn)
    $fell(|txAnalogReset) |-> $past(pllLocked));

  // R5: digital release happens with analog already low
  a_r5_dig_after_ana: assert property (@(posedge clk) disable iff (rstIn)
    $fell(|txDigitalReset) |-> ($past(txAnalogReset) == '0));

  // R7: losing ready outside reset leaves analog released
  a_r7_keep_analog: assert property (@(posedge clk) disable iff (rstIn)
    $fell(|txReady) |-> (txAnalogReset == '0));

  // R8: manual recovery keeps ready
  a_r8_manual_hold: assert property (@(posedge clk) disable iff (rstIn)
    (manualNow && $past(manualNow) && $past(&txReady)) |-> (&txReady));
endmodule

bind tx_reset_seq tx_reset_seq_chk #(.NUM_CH(NUM_CH), .MODE(MODE)) chk_i (
  .clk(clk), .rstIn(rstIn), .pllLocked(pllLocked), .manualSel(manualSel),
  .pllPowerDown(pllPowerDown), .txAnalogReset(txAnalogReset),
  .txDigitalReset(txDigitalReset), .txReady(txReady)
);

// File: tb/tx_reset_seq_tb_top.sv
`timescale 1ns/1ps
module tx_reset_seq_tb_top;
  localparam int NCH = 2;

  typedef struct {
    int    kind;   // 0 pdn, 1 analog, 2 digital, 3 ready
    int    val;    // 0 all low, 1 all high
    int    cyc;
    string req;
  } ev_t;

  logic clk = 1'b0;
  logic rstIn = 1'b1;
  logic pllLocked = 1'b0;
  logic manualSel = 1'b0;
  logic pdn, fPdn;
  logic [NCH-1:0] ana, dig, rdy, fAna, fDig, fRdy;

  int cyc = 0;
  int tests = 0;
  int fails = 0;
  bit monOn = 1'b0;
  bit finished = 1'b0;
  ev_t expQ[$];
  int prevCode[4];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tx_reset_seq #(.NUM_CH(NCH)) dut_i (
    .clk(clk), .rstIn(rstIn), .pllLocked(pllLocked), .manualSel(manualSel),
    .pllPowerDown(pdn), .txAnalogReset(ana), .txDigitalReset(dig), .txReady(rdy)
  );

  tx_reset_seq #(.NUM_CH(NCH), .FAST_SIM(1'b1), .LOCK_HYST_NS(0),
                 .SYNC_RST(1'b0), .MODE(0)) fast_i (
    .clk(clk), .rstIn(rstIn), .pllLocked(pllLocked), .manualSel(manualSel),
    .pllPowerDown(fPdn), .txAnalogReset(fAna), .txDigitalReset(fDig), .txReady(fRdy)
  );

  function automatic int vc(logic [NCH-1:0] v);
    if (v == '1) return 1;
    if (v == '0) return 0;
    return 2;
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push(int kind, int val, int at, string req);
    ev_t e;
    e.kind = kind; e.val = val; e.cyc = at; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic atCyc(int t);
    while (cyc < t) @(negedge clk);
  endtask

  // monitor: pop expected edges as outputs change
  always @(negedge clk) begin
    if (monOn) begin
      int cur[4];
      cur[0] = int'(pdn); cur[1] = vc(ana); cur[2] = vc(dig); cur[3] = vc(rdy);
      for (int k = 0; k < 4; k++) begin
        if (cur[k] != prevCode[k]) begin
          if (expQ.size() == 0) begin
            tests++; fails++;
            $display("FAIL unexpected edge: actual output %0d -> %0d expected no change (cycle %0d)",
                     k, cur[k], cyc);
          end else begin
            ev_t e;
            e = expQ.pop_front();
            chk({e.req, " output"}, k, e.kind);
            chk({e.req, " value"}, cur[k], e.val);
            chk({e.req, " cycle"}, cyc, e.cyc);
          end
          prevCode[k] = cur[k];
        end
      end
    end
  end

  task automatic expectBringUp(int c0, string tag);
    // 2 sync + 50 pdn, +1 lock seen, +10 analog, +5 digital
    push(0, 0, c0 + 52, {"R1 R3 ", tag});
    push(1, 0, c0 + 63, {"R4 ", tag});
    push(2, 0, c0 + 68, {"R5 ", tag});
    push(3, 1, c0 + 68, {"R5 ", tag});
  endtask

  initial begin
    int c0, l, m, p, q, r, c1, c2;
    repeat (4) @(negedge clk);
    // R2 reset state
    chk("R2 pdn", int'(pdn), 1);
    chk("R2 analog", vc(ana), 1);
    chk("R2 digital", vc(dig), 1);
    chk("R2 ready", vc(rdy), 0);
    chk("R2 fast ready", vc(fRdy), 0);
    prevCode[0] = 1; prevCode[1] = 1; prevCode[2] = 1; prevCode[3] = 0;
    monOn = 1'b1;
    #1 pllLocked = 1'b1;
    @(negedge clk);
    #1 rstIn = 1'b0;
    c0 = cyc;
    expectBringUp(c0, "bring-up");
    // R10 and R3 unsynchronized: fast counts 4,1,1
    atCyc(c0 + 3); chk("R10 fast pdn held", int'(fPdn), 1);
    atCyc(c0 + 4); chk("R10 fast pdn release", int'(fPdn), 0);
    atCyc(c0 + 6); chk("R10 fast ready early", vc(fRdy), 0);
    atCyc(c0 + 7); chk("R10 fast ready", vc(fRdy), 1);
    atCyc(c0 + 75);
    chk("R5 bring-up complete", expQ.size(), 0);

    // R7 automatic recovery
    #1 pllLocked = 1'b0;
    l = cyc;
    push(2, 1, l + 2, "R7 relock digital");
    push(3, 0, l + 2, "R7 relock ready");
    atCyc(l + 1); chk("R6 zero hysteresis fast drop", vc(fRdy), 0);
    // R6 short pulse ignored
    atCyc(l + 10); #1 pllLocked = 1'b1;
    atCyc(l + 15); #1 pllLocked = 1'b0;
    atCyc(l + 25);
    chk("R6 glitch digital", vc(dig), 1);
    chk("R6 glitch ready", vc(rdy), 0);
    #1 pllLocked = 1'b1;
    m = cyc;
    push(2, 0, m + 16, "R6 R7 relock release");
    push(3, 1, m + 16, "R7 relock ready");
    atCyc(m + 20);
    chk("R7 analog stayed low", vc(ana), 0);
    chk("R7 relock done", expQ.size(), 0);

    // R8 manual select at run time
    #1 manualSel = 1'b1;
    p = cyc;
    atCyc(p + 2); #1 pllLocked = 1'b0;
    atCyc(p + 22);
    chk("R8 manual ready", vc(rdy), 1);
    chk("R8 manual digital", vc(dig), 0);
    #1 pllLocked = 1'b1;
    atCyc(p + 40); #1 manualSel = 1'b0;
    atCyc(p + 42); #1 pllLocked = 1'b0;
    q = cyc;
    push(2, 1, q + 2, "R8 auto again digital");
    push(3, 0, q + 2, "R8 auto again ready");
    atCyc(q + 5); #1 pllLocked = 1'b1;
    m = cyc;
    push(2, 0, m + 16, "R8 auto release");
    push(3, 1, m + 16, "R8 auto ready");
    atCyc(m + 20);
    chk("R8 auto done", expQ.size(), 0);

    // R9 reset at run time, then reset again during power-down
    #1 rstIn = 1'b1;
    r = cyc;
    push(0, 1, r + 1, "R9 pdn");
    push(1, 1, r + 1, "R9 analog");
    push(2, 1, r + 1, "R9 digital");
    push(3, 0, r + 1, "R9 ready");
    atCyc(r + 4);
    chk("R9 reset applied", expQ.size(), 0);
    #1 rstIn = 1'b0;
    c1 = cyc;
    atCyc(c1 + 30); #1 rstIn = 1'b1;
    atCyc(c1 + 33); #1 rstIn = 1'b0;
    c2 = cyc;
    expectBringUp(c2, "R9 restart");
    atCyc(c2 + 51); chk("R9 pdn still held", int'(pdn), 1);
    atCyc(c2 + 75);
    chk("R9 restart complete", expQ.size(), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule